// File: doc/BRIEF.md
# Floating-Point Mantissa/Exponent Splitter for Reciprocal and Root Seeds

This unit takes one single-precision operand and breaks it into the pieces that reciprocal, square-root and reciprocal-square-root routines need as their starting point. Viewing a normal input as m·2^e with m in [1,2), it produces one of two kinds of answer. A mantissa operation returns a float rescaled into a narrow range. An exponent operation returns a small signed integer that the caller later folds back into the final result. The reciprocal mantissa lands in [0.5,1). The square-root mantissa is scaled by a power of four, so that the leftover exponent is even, and lands in [0.25,1).

An operation select picks one of five functions. The 32-bit result is read as a float or as a two's-complement integer, depending on the function. The output is registered. A valid input produces a valid output one clock later, and the result word holds its value while no new input arrives. Subnormal inputs are flushed to zero before any other processing.

Top module: `fsplit_unit`

## Requirements
- R1: Select code 0 (reciprocal mantissa): for a normal input, the result keeps the input sign bit [31] and fraction bits [22:0] and sets the exponent field [30:23] to 126, giving the value m·2^-1.
- R2: Select code 1 (square-root mantissa): for a normal input, the sign and fraction are kept. The exponent field is 125 when the unbiased exponent e = field-127 is even and 126 when e is odd.
- R3: Select code 2 (reciprocal exponent): for a normal input, the result is the integer -e-1 in 32-bit two's complement.
- R4: Select code 3 (square-root exponent): for a normal input, the result is floor(e/2)+1 in 32-bit two's complement. The floor rounds toward negative infinity, so e=-3 gives -1.
- R5: Select code 4 (reciprocal-square-root exponent): for a normal input, the result is -floor(e/2)-1 in 32-bit two's complement.
- R6: The three exponent operations (codes 2, 3, 4) return 0 when the input exponent field is 0 (zero) or 255 (infinity, NaN).
- R7: The two mantissa operations (codes 0, 1) pass an input with exponent field 255 through unchanged. For an input with exponent field 0, they return a zero that carries the input sign bit.
- R8: A subnormal input (exponent field 0, fraction nonzero) is treated exactly like a zero of the same sign by every operation.
- R9: Select codes 5, 6 and 7 return 0.
- R10: out_valid equals in_valid delayed by one clock. The result register loads only on a clock where in_valid is high and otherwise holds its value.
- R11: While rst is high at a clock edge, out_valid and result are cleared to 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and select are valid this cycle |
| op_sel | input | 3 | Operation select (0..4 defined, 5..7 give 0) |
| operand | input | 32 | Single-precision input word |
| out_valid | output | 1 | Result word holds a new value |
| result | output | 32 | Rescaled float or signed integer term |

## Verification
The operations are tried with operands whose unbiased exponents are positive and negative, odd and even, including -1, -3 and the extremes -126 and +127. These exponents separate a floor from a truncating divide, and they separate the 125 and 126 exponent fields of the square-root mantissa. Signed zeros, infinities, a NaN with payload and a subnormal tell apart the special-case paths of the mantissa operations from those of the exponent operations. The unused select codes are applied to a normal operand that would otherwise give a nonzero result. Back-to-back and idle-gap sequences tell the one-cycle latency apart from the hold behaviour of the result register.

// File: rtl/fsplit_pkg.sv
`timescale 1ns/1ps
package fsplit_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int OP_W   = 3;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SEXP_W = EXP_W + 2;
    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

    typedef enum logic [OP_W-1:0] {
        OP_RCP_MANT  = 0,
        OP_SQRT_MANT = 1,
        OP_RCP_EXP   = 2,
        OP_SQRT_EXP  = 3,
        OP_RSQ_EXP   = 4
    } op_e;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_NORM    = 2'd1,
        CLS_SPECIAL = 2'd2
    } cls_e;

    typedef struct packed {
        logic                     sign;
        cls_e                     cls;
        logic signed [SEXP_W-1:0] uexp;
        logic [FRAC_W-1:0]        frac;
        logic [WORD_W-1:0]        raw;
    } fields_t;

    // Arithmetic halving: rounds toward negative infinity.
    function automatic logic signed [SEXP_W-1:0] floor_half(input logic signed [SEXP_W-1:0] e);
        return e >>> 1;
    endfunction

    function automatic logic [WORD_W-1:0] sext_word(input logic signed [SEXP_W-1:0] v);
        return {{(WORD_W-SEXP_W){v[SEXP_W-1]}}, v};
    endfunction
endpackage

// File: rtl/fsplit_classify.sv
`timescale 1ns/1ps
module fsplit_classify
    import fsplit_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fields_t           f
);
    logic [EXP_W-1:0]  efld;
    logic [FRAC_W-1:0] ffld;

    assign efld = word[WORD_W-2 -: EXP_W];
    assign ffld = word[FRAC_W-1:0];

    always_comb begin
        f.sign = word[WORD_W-1];
        f.raw  = word;
        // Subnormals fold into the zero class: fraction is discarded.
        if (efld == '0) begin
            f.cls  = CLS_ZERO;
            f.frac = '0;
        end else if (efld == EXP_ALL1) begin
            f.cls  = CLS_SPECIAL;
            f.frac = ffld;
        end else begin
            f.cls  = CLS_NORM;
            f.frac = ffld;
        end
        f.uexp = $signed(SEXP_W'(efld)) - $signed(SEXP_W'(BIAS));
    end
endmodule

// File: rtl/fsplit_mant.sv
`timescale 1ns/1ps
module fsplit_mant
    import fsplit_pkg::*;
(
    input  fields_t           f,
    input  logic              sqrt_mode,
    output logic [WORD_W-1:0] mant
);
    localparam logic [EXP_W-1:0] FLD_HALF    = EXP_W'(BIAS - 1);
    localparam logic [EXP_W-1:0] FLD_QUARTER = EXP_W'(BIAS - 2);

    logic [EXP_W-1:0] new_fld;

    // Even exponent in root mode takes an extra factor of 1/2 so the
    // remaining exponent stays even.
    assign new_fld = (sqrt_mode && !f.uexp[0]) ? FLD_QUARTER : FLD_HALF;

    always_comb begin
        unique case (f.cls)
            CLS_NORM:    mant = {f.sign, new_fld, f.frac};
            CLS_SPECIAL: mant = f.raw;
            default:     mant = {f.sign, {(WORD_W-1){1'b0}}};
        endcase
    end
endmodule

// File: rtl/fsplit_expo.sv
`timescale 1ns/1ps
module fsplit_expo
    import fsplit_pkg::*;
(
    input  fields_t           f,
    input  logic [OP_W-1:0]   op,
    output logic [WORD_W-1:0] ival
);
    localparam logic signed [SEXP_W-1:0] ONE = $signed(SEXP_W'(1));

    logic signed [SEXP_W-1:0] half;
    logic signed [SEXP_W-1:0] term;

    assign half = floor_half(f.uexp);

    always_comb begin
        case (op)
            OP_RCP_EXP:  term = -f.uexp - ONE;
            OP_SQRT_EXP: term = half + ONE;
            OP_RSQ_EXP:  term = -half - ONE;
            default:     term = '0;
        endcase
        ival = (f.cls == CLS_NORM) ? sext_word(term) : '0;
    end
endmodule

// File: rtl/fsplit_unit.sv
`timescale 1ns/1ps
module fsplit_unit
    import fsplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [WORD_W-1:0] operand,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    fields_t           flds;
    logic [WORD_W-1:0] mant_w;
    logic [WORD_W-1:0] expo_w;
    logic [WORD_W-1:0] next_w;
    logic              is_mant;
    logic              is_expo;
    logic              sqrt_mode;

    assign is_mant   = (op_sel == OP_RCP_MANT) || (op_sel == OP_SQRT_MANT);
    assign is_expo   = (op_sel == OP_RCP_EXP) || (op_sel == OP_SQRT_EXP) ||
                       (op_sel == OP_RSQ_EXP);
    assign sqrt_mode = (op_sel == OP_SQRT_MANT);

    fsplit_classify u_cls  (.word(operand), .f(flds));
    fsplit_mant     u_mant (.f(flds), .sqrt_mode(sqrt_mode), .mant(mant_w));
    fsplit_expo     u_expo (.f(flds), .op(op_sel), .ival(expo_w));

    always_comb begin
        if (is_mant)      next_w = mant_w;
        else if (is_expo) next_w = expo_w;
        else              next_w = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_w;
        end
    end

    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R10
    vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));
    // R6
    expo_special_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_expo && flds.cls != CLS_NORM) |=> (result == '0));
    // R7
    mant_sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_mant) |=> (result[WORD_W-1] == $past(operand[WORD_W-1])));
    // R9
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_mant && !is_expo) |=> (result == '0));
    // R2
    sqrt_even_fld_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sqrt_mode && flds.cls == CLS_NORM && !flds.uexp[0]) |=>
        (result[WORD_W-2 -: EXP_W] == EXP_W'(BIAS - 2)));
    // R4
    sqrt_exp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == OP_SQRT_EXP) |=>
        ($signed(result) >= -63 && $signed(result) <= 64));
endmodule

// File: tb/fsplit_unit_bench.sv
`timescale 1ns/1ps
module fsplit_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] operand = 32'd0;
    logic        out_valid;
    logic [31:0] result;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    fsplit_unit u_fsplit_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .operand(operand), .out_valid(out_valid), .result(result)
    );

    always #10 clk = ~clk;

    // Independent reference built from the requirement text.
    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] x);
        int ef = int'(x[30:23]);
        int e  = ef - 127;
        int fl = (e >= 0) ? e / 2 : -((1 - e) / 2);
        bit zr = (ef == 0);
        bit sp = (ef == 255);
        case (op)
            3'd0, 3'd1: begin
                if (sp) return x;
                if (zr) return {x[31], 31'd0};
                if (op == 3'd1 && (e % 2) == 0) return {x[31], 8'd125, x[22:0]};
                return {x[31], 8'd126, x[22:0]};
            end
            3'd2: return (zr || sp) ? 32'd0 : 32'(-e - 1);
            3'd3: return (zr || sp) ? 32'd0 : 32'(fl + 1);
            3'd4: return (zr || sp) ? 32'd0 : 32'(-fl - 1);
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [2:0] op, input logic [31:0] x);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; operand = x;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, result, model(op, x));
        check({tag, " out_valid"}, {31'd0, out_valid}, 32'd1);
    endtask

    task automatic t_reset;
        in_valid = 1'b1; op_sel = 3'd3; operand = 32'h4040_0000;
        repeat (3) @(negedge clk);
        check("R11 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R11 reset result", result, 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_rcp_mant;
        run_op("R1 rcp mant 1.0",   3'd0, 32'h3F80_0000);
        run_op("R1 rcp mant -5.0",  3'd0, 32'hC0A0_0000);
        run_op("R1 rcp mant 0.1",   3'd0, 32'h3DCC_CCCD);
        run_op("R1 rcp mant max",   3'd0, 32'h7F7F_FFFF);
    endtask

    task automatic t_sqrt_mant;
        run_op("R2 sqrt mant e=0",  3'd1, 32'h3F80_0000);
        run_op("R2 sqrt mant e=1",  3'd1, 32'h4040_0000);
        run_op("R2 sqrt mant e=-1", 3'd1, 32'h3F40_0000);
        run_op("R2 sqrt mant e=-4", 3'd1, 32'hBDCC_CCCD);
        run_op("R2 sqrt mant e=-3", 3'd1, 32'h3E00_0000);
    endtask

    task automatic t_rcp_exp;
        run_op("R3 rcp exp e=0",    3'd2, 32'h3F80_0000);
        run_op("R3 rcp exp e=3",    3'd2, 32'h4100_0000);
        run_op("R3 rcp exp e=-126", 3'd2, 32'h0080_0000);
        run_op("R3 rcp exp e=127",  3'd2, 32'h7F7F_FFFF);
    endtask

    task automatic t_sqrt_exp;
        run_op("R4 sqrt exp e=3",    3'd3, 32'h4100_0000);
        run_op("R4 sqrt exp e=-1",   3'd3, 32'h3F40_0000);
        run_op("R4 sqrt exp e=-3",   3'd3, 32'h3E00_0000);
        run_op("R4 sqrt exp e=-126", 3'd3, 32'h0080_0000);
    endtask

    task automatic t_rsq_exp;
        run_op("R5 rsq exp e=2",   3'd4, 32'hC0A0_0000);
        run_op("R5 rsq exp e=-1",  3'd4, 32'h3F40_0000);
        run_op("R5 rsq exp e=-3",  3'd4, 32'h3E00_0000);
        run_op("R5 rsq exp e=127", 3'd4, 32'h7F7F_FFFF);
    endtask

    task automatic t_exp_specials;
        for (int op = 2; op <= 4; op++) begin
            run_op("R6 exp of +0",   3'(op), 32'h0000_0000);
            run_op("R6 exp of -inf", 3'(op), 32'hFF80_0000);
            run_op("R6 exp of NaN",  3'(op), 32'h7FC0_0001);
        end
    endtask

    task automatic t_mant_specials;
        for (int op = 0; op <= 1; op++) begin
            run_op("R7 mant of +inf", 3'(op), 32'h7F80_0000);
            run_op("R7 mant of NaN",  3'(op), 32'hFFC1_2345);
            run_op("R7 mant of -0",   3'(op), 32'h8000_0000);
            run_op("R7 mant of +0",   3'(op), 32'h0000_0000);
        end
    endtask

    task automatic t_subnormal;
        for (int op = 0; op <= 4; op++) begin
            run_op("R8 subnormal pos", 3'(op), 32'h0040_0000);
            run_op("R8 subnormal neg", 3'(op), 32'h8000_0001);
        end
    endtask

    task automatic t_unused;
        for (int op = 5; op <= 7; op++) begin
            run_op("R9 unused code", 3'(op), 32'h4100_0000);
        end
    endtask

    task automatic t_timing;
        logic [31:0] held;
        run_op("R10 setup", 3'd3, 32'h4100_0000);
        held = result;
        // Idle cycles with changing inputs must not disturb the result.
        op_sel = 3'd2; operand = 32'h3E00_0000;
        @(negedge clk);
        check("R10 idle out_valid low", {31'd0, out_valid}, 32'd0);
        check("R10 idle result held", result, held);
        @(negedge clk);
        check("R10 idle result held 2", result, held);
        // Latency: nothing visible before the capturing edge.
        in_valid = 1'b1; op_sel = 3'd2; operand = 32'h3F80_0000;
        #1;
        check("R10 no zero-latency valid", {31'd0, out_valid}, 32'd0);
        check("R10 no zero-latency result", result, held);
        @(negedge clk);
        op_sel = 3'd1; operand = 32'h3F40_0000;
        check("R10 stream first", result, model(3'd2, 32'h3F80_0000));
        check("R10 stream valid", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 stream second", result, model(3'd1, 32'h3F40_0000));
        @(negedge clk);
        check("R10 stream end valid", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_reset_mid;
        run_op("R11 pre-reset", 3'd0, 32'h4040_0000);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R11 mid reset result", result, 32'd0);
        check("R11 mid reset valid", {31'd0, out_valid}, 32'd0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_rcp_mant();
        t_sqrt_mant();
        t_rcp_exp();
        t_sqrt_exp();
        t_rsq_exp();
        t_exp_specials();
        t_mant_specials();
        t_subnormal();
        t_unused();
        t_timing();
        t_reset_mid();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule